// File: doc/BRIEF.md
# Dual-Master Expansion Slot Bus Adapter

This block connects two processor request ports to one expansion cartridge slot. The slot has two native buses: a 16-bit ROM bus and an 8-bit SRAM bus, each with its own request/acknowledge handshake. A one-bit ownership input selects which of the two processors may reach the slot. Accesses from the other processor finish at once without touching the slot: reads return zero and writes are dropped.

An owner access of 8, 16 or 32 bits is decoded by address window. It is then broken into a fixed sequence of native transactions. A single sequencer issues these one at a time in ascending address order, merges read data into a zero-extended result word, and slices write data across the transactions. The requesting port sees a one-cycle done pulse that carries the read data. Accesses from the owner that fall outside every slot window also finish at once, and they raise a sticky error flag.

Top module: `slot_bus_adapter`

## Requirements
- R1: With `own_sel`=0 port A owns the slot; with `own_sel`=1 port B owns it. A read from the port that does not own the slot completes with a done pulse and all-zero read data, and issues no slot transaction.
- R2: A write from the port that does not own the slot completes with a done pulse and issues no slot transaction.
- R3: Address bits [31:24] equal to 0x08 or 0x09 select the ROM bus; 0x0A selects the SRAM bus. The size code is 0 = byte, 1 = halfword, 2 = word.
- R4: A byte read in a ROM window issues one ROM read at the address with bit 0 cleared. It returns bits [15:8] when address bit 0 is 1 and bits [7:0] when it is 0, zero-extended to 32 bits.
- R5: A halfword ROM access is one ROM transaction at the even address. A word ROM access is two: the low halfword at the address and then the high halfword at the address plus 2.
- R6: A byte write in a ROM window issues no transaction, completes with a done pulse and does not raise the error flag.
- R7: SRAM accesses of byte, halfword and word size issue 1, 2 and 4 byte transactions at consecutive ascending addresses. The lowest address carries the least significant byte, for both merge and split.
- R8: A slot request stays high with a stable address until it is acknowledged, and it drops for at least one cycle between sub-transactions. The ROM and SRAM requests are never high together.
- R9: `x_done` pulses for one cycle only after every sub-transaction has been acknowledged, and `x_rdata` is zero while `x_done` is low. `x_busy` is high while that port's request is high and its done is low. The two done outputs are never high together.
- R10: When both ports request in the same cycle, the owner's access is served first. The other port then completes with zero data and no transaction.
- R11: An owner access outside all three windows, or with size code 3, completes with zero data and no transaction. It sets `err_flag`, which stays set until reset.
- R12: During and right after reset no slot request and no done is active, and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_sel | input | 1 | Slot ownership: 0 = port A, 1 = port B |
| a_req | input | 1 | Port A request, held until done |
| a_we | input | 1 | Port A write enable |
| a_size | input | 2 | Port A size code |
| a_addr | input | 32 | Port A byte address |
| a_wdata | input | 32 | Port A write data |
| a_busy | output | 1 | Port A stall |
| a_done | output | 1 | Port A completion pulse |
| a_rdata | output | 32 | Port A read data, valid with done |
| b_req | input | 1 | Port B request, held until done |
| b_we | input | 1 | Port B write enable |
| b_size | input | 2 | Port B size code |
| b_addr | input | 32 | Port B byte address |
| b_wdata | input | 32 | Port B write data |
| b_busy | output | 1 | Port B stall |
| b_done | output | 1 | Port B completion pulse |
| b_rdata | output | 32 | Port B read data, valid with done |
| rom_req | output | 1 | ROM bus request |
| rom_we | output | 1 | ROM bus write |
| rom_addr | output | 32 | ROM bus byte address (even) |
| rom_wdata | output | 16 | ROM bus write data |
| rom_ack | input | 1 | ROM bus acknowledge |
| rom_rdata | input | 16 | ROM bus read data, valid with ack |
| sram_req | output | 1 | SRAM bus request |
| sram_we | output | 1 | SRAM bus write |
| sram_addr | output | 32 | SRAM bus byte address |
| sram_wdata | output | 8 | SRAM bus write data |
| sram_ack | input | 1 | SRAM bus acknowledge |
| sram_rdata | input | 8 | SRAM bus read data, valid with ack |
| err_flag | output | 1 | Sticky out-of-window error |

## Verification
The bench builds the block with its defaults: 32-bit addresses and words, a 16-bit ROM bus and an 8-bit SRAM bus. This reaches the deepest split the block has, four SRAM byte transactions for one word, as well as both ROM halfwords of a word. The slave model alternates between zero and two cycles of acknowledge delay, so sub-transactions are seen both back to back and held over several wait cycles. The ownership bit is flipped between vectors, so each port is tried both as owner and as non-owner.

// File: rtl/slot_pkg.sv
package slot_pkg;
  typedef enum logic [1:0] {BUS_NONE, BUS_ROM, BUS_SRAM} bus_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [7:0] WIN_ROM_LO  = 8'h08;
  localparam logic [7:0] WIN_ROM_HI  = 8'h09;
  localparam logic [7:0] WIN_SRAM    = 8'h0A;
endpackage

// File: rtl/slot_arbiter.sv
module slot_arbiter (
  input  logic a_req,
  input  logic b_req,
  input  logic own_b,
  output logic grant_valid,
  output logic grant_b,
  output logic grant_owner
);
  always_comb begin
    grant_valid = a_req | b_req;
    if (own_b) grant_b = b_req;
    else       grant_b = b_req & ~a_req;
    grant_owner = (grant_b == own_b);
  end
endmodule

// File: rtl/slot_planner.sv
module slot_planner
  import slot_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int ROM_LANES  = 2,
  parameter int SRAM_LANES = 4,
  parameter int HALF_BYTES = 2
) (
  input  logic [7:0]       win,
  input  logic [1:0]       size,
  input  logic             we,
  input  logic             owner,
  output bus_e             bus,
  output logic [CNT_W-1:0] count,
  output logic             err
);
  always_comb begin
    bus   = BUS_NONE;
    count = '0;
    err   = 1'b0;
    if (owner) begin
      if (size == 2'b11) begin
        err = 1'b1;
      end else if (win == WIN_ROM_LO || win == WIN_ROM_HI) begin
        bus = BUS_ROM;
        case (size)
          SZ_BYTE: count = we ? '0 : CNT_W'(1);
          SZ_HALF: count = CNT_W'(1);
          default: count = CNT_W'(ROM_LANES);
        endcase
      end else if (win == WIN_SRAM) begin
        bus = BUS_SRAM;
        case (size)
          SZ_BYTE: count = CNT_W'(1);
          SZ_HALF: count = CNT_W'(HALF_BYTES);
          default: count = CNT_W'(SRAM_LANES);
        endcase
      end else begin
        err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ROM_W  = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  logic              grant_b,
  input  bus_e              plan_bus,
  input  logic [CNT_W-1:0]  plan_cnt,
  input  logic              plan_err,
  input  logic              sel_we,
  input  logic [1:0]        sel_size,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [DATA_W-1:0] sel_wdata,
  output logic              rom_req,
  output logic              rom_we,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [ROM_W-1:0]  rom_wdata,
  input  logic              rom_ack,
  input  logic [ROM_W-1:0]  rom_rdata,
  output logic              sram_req,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [BYTE_W-1:0] sram_wdata,
  input  logic              sram_ack,
  input  logic [BYTE_W-1:0] sram_rdata,
  output logic              done_a,
  output logic              done_b,
  output logic [DATA_W-1:0] rdata,
  output logic              err_flag
);
  sq_e               state_q, state_d;
  logic              cur_b_q, we_q, err_q, err_d, cap;
  bus_e              bus_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, idx_q, idx_d;
  logic              ack;

  assign ack = (bus_q == BUS_ROM) ? rom_ack : sram_ack;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    err_d   = err_q;
    cap     = 1'b0;
    case (state_q)
      SQ_IDLE: if (grant_valid) begin
        cap     = 1'b1;
        idx_d   = '0;
        acc_d   = '0;
        err_d   = err_q | plan_err;
        state_d = (plan_cnt == '0) ? SQ_DONE : SQ_ISSUE;
      end
      SQ_ISSUE: state_d = SQ_WAIT;
      SQ_WAIT: if (ack) begin
        if (!we_q) begin
          if (bus_q == BUS_ROM) begin
            if (size_q == SZ_BYTE)
              acc_d[BYTE_W-1:0] = addr_q[0] ? rom_rdata[BYTE_W +: BYTE_W]
                                            : rom_rdata[BYTE_W-1:0];
            else
              acc_d[int'(idx_q)*ROM_W +: ROM_W] = rom_rdata;
          end else begin
            acc_d[int'(idx_q)*BYTE_W +: BYTE_W] = sram_rdata;
          end
        end
        idx_d   = idx_q + 1'b1;
        state_d = (idx_d == cnt_q) ? SQ_DONE : SQ_ISSUE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_b_q <= 1'b0;
      we_q    <= 1'b0;
      bus_q   <= BUS_NONE;
      size_q  <= SZ_BYTE;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else if (cap) begin
      cur_b_q <= grant_b;
      we_q    <= sel_we;
      bus_q   <= plan_bus;
      size_q  <= sel_size;
      addr_q  <= sel_addr;
      wdata_q <= sel_wdata;
      cnt_q   <= plan_cnt;
    end
  end

  always_comb begin
    rom_req    = (state_q == SQ_WAIT) && (bus_q == BUS_ROM);
    sram_req   = (state_q == SQ_WAIT) && (bus_q == BUS_SRAM);
    rom_we     = rom_req & we_q;
    sram_we    = sram_req & we_q;
    rom_addr   = {addr_q[ADDR_W-1:1], 1'b0} + (ADDR_W'(idx_q) << 1);
    sram_addr  = addr_q + ADDR_W'(idx_q);
    rom_wdata  = wdata_q[int'(idx_q)*ROM_W +: ROM_W];
    sram_wdata = wdata_q[int'(idx_q)*BYTE_W +: BYTE_W];
    done_a     = (state_q == SQ_DONE) && !cur_b_q;
    done_b     = (state_q == SQ_DONE) && cur_b_q;
    rdata      = (state_q == SQ_DONE) ? acc_q : '0;
    err_flag   = err_q;
  end

  // R8
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_req && sram_req));
  // R8
  rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_ack) |=> (rom_req && $stable(rom_addr)));
  // R8
  sram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req && !sram_ack) |=> (sram_req && $stable(sram_addr)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_a || done_b) |=> !(done_a || done_b));
  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_a, done_b}));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

// File: rtl/slot_bus_adapter.sv
module slot_bus_adapter
  import slot_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ROM_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_sel,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [1:0]        a_size,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_busy,
  output logic              a_done,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [1:0]        b_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              b_busy,
  output logic              b_done,
  output logic [DATA_W-1:0] b_rdata,
  output logic              rom_req,
  output logic              rom_we,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [ROM_W-1:0]  rom_wdata,
  input  logic              rom_ack,
  input  logic [ROM_W-1:0]  rom_rdata,
  output logic              sram_req,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [BYTE_W-1:0] sram_wdata,
  input  logic              sram_ack,
  input  logic [BYTE_W-1:0] sram_rdata,
  output logic              err_flag
);
  localparam int ROM_LANES  = DATA_W / ROM_W;
  localparam int SRAM_LANES = DATA_W / BYTE_W;
  localparam int HALF_BYTES = ROM_W / BYTE_W;
  localparam int CNT_W      = $clog2(SRAM_LANES + 1);

  logic              grant_valid, grant_b, grant_owner;
  logic              sel_we;
  logic [1:0]        sel_size;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata, rdata;
  bus_e              plan_bus;
  logic [CNT_W-1:0]  plan_cnt;
  logic              plan_err, done_a, done_b;

  slot_arbiter u_arb (
    .a_req(a_req), .b_req(b_req), .own_b(own_sel),
    .grant_valid(grant_valid), .grant_b(grant_b), .grant_owner(grant_owner)
  );

  always_comb begin
    sel_we    = grant_b ? b_we    : a_we;
    sel_size  = grant_b ? b_size  : a_size;
    sel_addr  = grant_b ? b_addr  : a_addr;
    sel_wdata = grant_b ? b_wdata : a_wdata;
  end

  slot_planner #(
    .CNT_W(CNT_W), .ROM_LANES(ROM_LANES),
    .SRAM_LANES(SRAM_LANES), .HALF_BYTES(HALF_BYTES)
  ) u_plan (
    .win(sel_addr[ADDR_W-1 -: 8]), .size(sel_size), .we(sel_we),
    .owner(grant_owner), .bus(plan_bus), .count(plan_cnt), .err(plan_err)
  );

  slot_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_W(ROM_W),
    .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .grant_valid(grant_valid), .grant_b(grant_b),
    .plan_bus(plan_bus), .plan_cnt(plan_cnt), .plan_err(plan_err),
    .sel_we(sel_we), .sel_size(sel_size), .sel_addr(sel_addr), .sel_wdata(sel_wdata),
    .rom_req(rom_req), .rom_we(rom_we), .rom_addr(rom_addr), .rom_wdata(rom_wdata),
    .rom_ack(rom_ack), .rom_rdata(rom_rdata),
    .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_ack(sram_ack), .sram_rdata(sram_rdata),
    .done_a(done_a), .done_b(done_b), .rdata(rdata), .err_flag(err_flag)
  );

  always_comb begin
    a_done  = done_a;
    b_done  = done_b;
    a_rdata = done_a ? rdata : '0;
    b_rdata = done_b ? rdata : '0;
    a_busy  = a_req & ~done_a;
    b_busy  = b_req & ~done_b;
  end
endmodule

// File: tb/tb_slot_bus_adapter.sv
module tb_slot_bus_adapter;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, own_sel;
  logic a_req, a_we, b_req, b_we;
  logic [1:0] a_size, b_size;
  logic [31:0] a_addr, a_wdata, b_addr, b_wdata;
  logic a_busy, a_done, b_busy, b_done;
  logic [31:0] a_rdata, b_rdata;
  logic rom_req, rom_we, rom_ack, sram_req, sram_we, sram_ack, err_flag;
  logic [31:0] rom_addr, sram_addr;
  logic [15:0] rom_wdata, rom_rdata;
  logic [7:0]  sram_wdata, sram_rdata;

  slot_bus_adapter dut (.*);

  int checks = 0, fails = 0, cyc = 0, lat = 0;
  int tx_cnt, rom_wait, sram_wait;
  logic [31:0] tx_first, tx_last;
  logic [15:0] tx_lastw;

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end
  initial forever begin @(posedge clk); cyc++; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slot slave: ROM data = addr[15:0] + 0x1000, SRAM data = ~addr[7:0]
  initial begin
    rom_ack = 0; sram_ack = 0; rom_rdata = 0; sram_rdata = 0;
    rom_wait = 0; sram_wait = 0;
    forever begin
      @(negedge clk);
      if (rom_req && !rom_ack) begin
        if (rom_wait < lat) rom_wait++;
        else begin
          rom_wait = 0; rom_ack = 1; rom_rdata = rom_addr[15:0] + 16'h1000;
          tx_cnt++; if (tx_cnt == 1) tx_first = rom_addr;
          tx_last = rom_addr; tx_lastw = rom_we ? rom_wdata : 16'h0;
        end
      end else rom_ack = 0;
      if (sram_req && !sram_ack) begin
        if (sram_wait < lat) sram_wait++;
        else begin
          sram_wait = 0; sram_ack = 1; sram_rdata = ~sram_addr[7:0];
          tx_cnt++; if (tx_cnt == 1) tx_first = sram_addr;
          tx_last = sram_addr; tx_lastw = sram_we ? {8'h0, sram_wdata} : 16'h0;
        end
      end else sram_ack = 0;
    end
  end

  task automatic access(input bit port, input bit we, input logic [1:0] sz,
                        input logic [31:0] ad, input logic [31:0] wd,
                        output logic [31:0] rd, output int dcyc);
    bit got = 0;
    @(negedge clk);
    if (port) begin b_req = 1; b_we = we; b_size = sz; b_addr = ad; b_wdata = wd; end
    else      begin a_req = 1; a_we = we; a_size = sz; a_addr = ad; a_wdata = wd; end
    rd = 32'hDEAD_BEEF; dcyc = 0;
    for (int k = 0; k < 300 && !got; k++) begin
      @(negedge clk);
      if (port ? b_done : a_done) begin
        rd = port ? b_rdata : a_rdata; dcyc = cyc; got = 1;
        if (port) b_req = 0; else a_req = 0;
      end
    end
    if (!got) begin
      checks++; fails++;
      $display("FAIL R9 no done actual=0 expected=1");
      if (port) b_req = 0; else a_req = 0;
    end
  endtask

  typedef struct packed {
    logic [7:0]  rq;
    logic        port;
    logic        own;
    logic        we;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] erd;
    logic [2:0]  ntx;
    logic [31:0] first;
    logic [31:0] last;
    logic [15:0] lastw;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 1'b0,1'b0,1'b0,2'd0, 32'h08000124, 32'h0, 32'h00000024, 3'd1, 32'h08000124, 32'h08000124, 16'h0},    // R4 low lane
    '{8'd4, 1'b0,1'b0,1'b0,2'd0, 32'h08000125, 32'h0, 32'h00000011, 3'd1, 32'h08000124, 32'h08000124, 16'h0},    // R4 high lane
    '{8'd3, 1'b0,1'b0,1'b0,2'd1, 32'h09000200, 32'h0, 32'h00001200, 3'd1, 32'h09000200, 32'h09000200, 16'h0},    // R3 second ROM window
    '{8'd5, 1'b0,1'b0,1'b0,2'd2, 32'h08000300, 32'h0, 32'h13021300, 3'd2, 32'h08000300, 32'h08000302, 16'h0},    // R5 word read
    '{8'd5, 1'b0,1'b0,1'b1,2'd1, 32'h08000400, 32'h0000BEEF, 32'h0, 3'd1, 32'h08000400, 32'h08000400, 16'hBEEF}, // R5 half write
    '{8'd5, 1'b0,1'b0,1'b1,2'd2, 32'h08000500, 32'hCAFE1234, 32'h0, 3'd2, 32'h08000500, 32'h08000502, 16'hCAFE}, // R5 word write
    '{8'd6, 1'b0,1'b0,1'b1,2'd0, 32'h08000600, 32'h000000AA, 32'h0, 3'd0, 32'h0, 32'h0, 16'h0},                  // R6 byte write dropped
    '{8'd7, 1'b0,1'b0,1'b0,2'd0, 32'h0A000040, 32'h0, 32'h000000BF, 3'd1, 32'h0A000040, 32'h0A000040, 16'h0},    // R7 byte
    '{8'd7, 1'b0,1'b0,1'b0,2'd1, 32'h0A000041, 32'h0, 32'h0000BDBE, 3'd2, 32'h0A000041, 32'h0A000042, 16'h0},    // R7 half
    '{8'd7, 1'b0,1'b0,1'b0,2'd2, 32'h0A000040, 32'h0, 32'hBCBDBEBF, 3'd4, 32'h0A000040, 32'h0A000043, 16'h0},    // R7 word
    '{8'd7, 1'b0,1'b0,1'b1,2'd2, 32'h0A000080, 32'h44332211, 32'h0, 3'd4, 32'h0A000080, 32'h0A000083, 16'h0044}, // R7 word write
    '{8'd7, 1'b0,1'b0,1'b1,2'd1, 32'h0A000090, 32'h0000A1B2, 32'h0, 3'd2, 32'h0A000090, 32'h0A000091, 16'h00A1}, // R7 half write
    '{8'd1, 1'b1,1'b0,1'b0,2'd2, 32'h08000300, 32'h0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h0},                         // R1 B not owner
    '{8'd2, 1'b1,1'b0,1'b1,2'd0, 32'h0A000010, 32'h55, 32'h0, 3'd0, 32'h0, 32'h0, 16'h0},                        // R2 B not owner
    '{8'd1, 1'b1,1'b1,1'b0,2'd1, 32'h08000700, 32'h0, 32'h00001700, 3'd1, 32'h08000700, 32'h08000700, 16'h0},    // R1 B owner
    '{8'd1, 1'b0,1'b1,1'b0,2'd2, 32'h0A000040, 32'h0, 32'h0, 3'd0, 32'h0, 32'h0, 16'h0},                         // R1 A not owner
    '{8'd2, 1'b0,1'b1,1'b1,2'd1, 32'h08000400, 32'h1111, 32'h0, 3'd0, 32'h0, 32'h0, 16'h0}                       // R2 A not owner
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd_b;
    int dc, dc_b;
    string tag;
    rst_n = 0; own_sel = 0;
    a_req = 0; a_we = 0; a_size = 0; a_addr = 0; a_wdata = 0;
    b_req = 0; b_we = 0; b_size = 0; b_addr = 0; b_wdata = 0;
    tx_cnt = 0; tx_first = 0; tx_last = 0; tx_lastw = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rom_req", {31'b0, rom_req}, 0);
    chk("R12 sram_req", {31'b0, sram_req}, 0);
    chk("R12 done", {30'b0, a_done, b_done}, 0);
    chk("R12 err", {31'b0, err_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 after release", {28'b0, rom_req, sram_req, a_done, b_done}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      lat = (i % 2 == 0) ? 0 : 2;
      own_sel = v.own;
      tx_cnt = 0; tx_first = 0; tx_last = 0; tx_lastw = 0;
      access(v.port, v.we, v.sz, v.addr, v.wd, rd, dc);
      repeat (2) @(negedge clk);
      $sformat(tag, "R%0d vec%0d rdata", v.rq, i); chk(tag, rd, v.erd);
      $sformat(tag, "R%0d vec%0d ntx", v.rq, i);   chk(tag, tx_cnt, {29'b0, v.ntx});
      if (v.ntx != 0) begin
        $sformat(tag, "R%0d vec%0d first", v.rq, i); chk(tag, tx_first, v.first);
        $sformat(tag, "R%0d vec%0d last", v.rq, i);  chk(tag, tx_last, v.last);
        if (v.we) begin
          $sformat(tag, "R%0d vec%0d lastw", v.rq, i); chk(tag, {16'b0, tx_lastw}, {16'b0, v.lastw});
        end
      end
    end
    chk("R6 no error from dropped writes", {31'b0, err_flag}, 0);

    // R9 busy while pending, rdata zero when not done
    own_sel = 0; lat = 3; tx_cnt = 0;
    @(negedge clk);
    a_req = 1; a_we = 0; a_size = 2; a_addr = 32'h0A000040;
    @(negedge clk); @(negedge clk);
    chk("R9 busy while pending", {31'b0, a_busy}, 1);
    chk("R9 rdata zero before done", a_rdata, 0);
    chk("R9 done not early", {31'b0, a_done}, 0);
    for (int k = 0; k < 100 && !a_done; k++) @(negedge clk);
    chk("R9 done after all acks", tx_cnt, 4);
    chk("R9 rdata at done", a_rdata, 32'hBCBDBEBF);
    a_req = 0;
    @(negedge clk);
    chk("R9 done one cycle", {31'b0, a_done}, 0);
    lat = 0;

    // R10 simultaneous: B owns, both request
    own_sel = 1; tx_cnt = 0;
    fork
      access(1'b1, 1'b0, 2'd2, 32'h08000300, 32'h0, rd_b, dc_b);
      access(1'b0, 1'b0, 2'd2, 32'h0A000040, 32'h0, rd, dc);
    join
    chk("R10 owner data", rd_b, 32'h13021300);
    chk("R10 non-owner zero", rd, 0);
    chk("R10 owner first", {31'b0, (dc_b < dc)}, 1);
    chk("R10 only owner transactions", tx_cnt, 2);

    // R11 out of window and bad size
    own_sel = 0; tx_cnt = 0;
    access(1'b0, 1'b0, 2'd2, 32'h0B000000, 32'h0, rd, dc);
    @(negedge clk);
    chk("R11 window miss zero", rd, 0);
    chk("R11 window miss no tx", tx_cnt, 0);
    chk("R11 err set", {31'b0, err_flag}, 1);
    access(1'b0, 1'b0, 2'd1, 32'h08000124, 32'h0, rd, dc);
    @(negedge clk);
    chk("R11 err sticky", {31'b0, err_flag}, 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R12 reset clears err", {31'b0, err_flag}, 0);
    tx_cnt = 0;
    access(1'b0, 1'b0, 2'd3, 32'h0A000040, 32'h0, rd, dc);
    @(negedge clk);
    chk("R11 size3 no tx", tx_cnt, 0);
    chk("R11 size3 err", {31'b0, err_flag}, 1);
    // R11 non-owner miss does not set err
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    access(1'b1, 1'b0, 2'd2, 32'h0C000000, 32'h0, rd, dc);
    @(negedge clk);
    chk("R1 non-owner miss no err", {31'b0, err_flag}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule